// File: doc/BRIEF.md
# I2C Register Target with Coherent Clock Snapshot

This block is the I2C target-side front end of a register-mapped peripheral. A bus host reaches a 64-byte register space through it by sending a word-address byte, then reading or writing a run of bytes. Each acknowledged byte steps an internal 6-bit pointer, and the pointer keeps its value from one transaction to the next. The pointer wraps from 3Fh to 00h. SCL and SDA arrive already synchronised. The block pulls SDA low only through an open-drain enable.

The eight lowest addresses show a bus-side copy of a live timekeeping register set. The live values come in as a parallel bus with an update strobe. While the block is taking part in a transaction and the pointer sits at 00h–07h, the copy is frozen, so a multi-byte read of the time fields stays coherent. Strobes that arrive during the freeze are remembered. The copy takes the newest live values as soon as a STOP ends the transaction or the pointer moves past 07h. Host writes to the clock range are not stored in the copy. They leave the block on a one-cycle load strobe for the counters. All other addresses are plain storage.

Top module: `i2c_snap_target`

## Requirements
- R1: The block acknowledges only the 7-bit target address 1101000 (address byte D0h for a write, D1h for a read). For any other address it keeps SDA released through the acknowledge clock.
- R2: In a write transaction, the first byte after the address acknowledge loads the low 6 bits of the word-address pointer.
- R3: Each later write byte is stored at the pointer and acknowledged, and the pointer then advances by one. It wraps from 3Fh to 00h.
- R4: In a read transaction the block sends the byte at the pointer, MSB first, and changes SDA only while SCL is low. Each byte the host acknowledges is followed by the byte at the next address.
- R5: When the host does not acknowledge a read byte, the pointer stays where it is and the block releases SDA until the next START or STOP.
- R6: The pointer keeps its value across STOP. A read with no word-address write starts at that value.
- R7: A write to 00h–07h gives one pulse of `clk_wr_o` lasting one clock cycle, carrying the low 3 bits of the address and the data byte. It does not change the bus-visible copy.
- R8: When no freeze is in effect, `live_upd_i` loads the bus-visible copy from `live_time_i`. Address k reads byte k, which is bits [8k+7:8k].
- R9: While the block is addressed and the pointer is at 00h–07h, the copy holds still. This stays true across a repeated START to the same target, and live updates during that time do not appear on the bus.
- R10: A freeze ends on STOP or when the pointer advances past 07h. The copy then takes the newest live value delivered by a strobe.
- R11: After reset, SDA is released, the pointer is 00h and the bus-visible copy is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| live_time_i | input | 64 | Live clock register values, byte k at bits [8k+7:8k] |
| live_upd_i | input | 1 | Strobe marking new live values |
| clk_wr_o | output | 1 | One-cycle load strobe for a host write to the clock range |
| clk_wr_addr_o | output | 3 | Clock register index for `clk_wr_o` |
| clk_wr_data_o | output | 8 | Data byte for `clk_wr_o` |

## Verification
Two events can land in the same cycle: a live update strobe, and the end of a freeze. The freeze ends either when STOP is detected or when the pointer steps past 07h on a host acknowledge. The bench provokes the collision by holding the update strobe high every cycle with a changing pattern across the STOP, and by updating during a burst read that crosses 07h. It then reads the clock range back. The result passes only if the bytes read inside the frozen window are the old values and every byte read afterwards is the newest pattern, never an older pending one.

// File: rtl/i2c_snap_pkg.sv
package i2c_snap_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK,
    ST_WAIT
  } tgt_state_e;

  localparam int BYTE_W = 8;
endpackage

// File: rtl/i2c_line_sense.sv
module i2c_line_sense (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise  = scl_i & ~scl_q;
  assign scl_fall  = ~scl_i & scl_q;
  assign start_det = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
  import i2c_snap_pkg::*;
#(
  parameter int         AW       = 6,
  parameter logic [6:0] TGT_ADDR = 7'h68
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_now,
  input  logic          sda_now,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [7:0]    rd_data,
  output logic          sda_oe,
  output logic [AW-1:0] ptr,
  output logic          active,
  output logic          wr_en,
  output logic [7:0]    wr_data
);
  tgt_state_e state;
  logic [3:0] bitcnt;
  logic [7:0] sr, tx;
  logic       rw, hack;
  logic [2:0] tx_idx;

  assign tx_idx = 3'd7 - bitcnt[2:0];

  always_ff @(posedge clk) begin
    wr_en <= 1'b0;
    if (rst) begin
      state   <= ST_IDLE;
      bitcnt  <= '0;
      sr      <= '0;
      tx      <= '0;
      sda_oe  <= 1'b0;
      ptr     <= '0;
      rw      <= 1'b0;
      hack    <= 1'b0;
      active  <= 1'b0;
      wr_data <= '0;
    end else if (start_det) begin
      state  <= ST_ADDR;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
      active <= 1'b0;
    end else begin
      if (scl_rise) begin
        case (state)
          ST_ADDR, ST_PTR, ST_WDATA: begin
            sr     <= {sr[6:0], sda_now};
            bitcnt <= bitcnt + 4'd1;
          end
          ST_RDATA: bitcnt <= bitcnt + 4'd1;
          ST_RACK: begin
            hack <= ~sda_now;
            if (!sda_now) ptr <= ptr + AW'(1);
          end
          default: ;
        endcase
      end
      if (scl_fall) begin
        case (state)
          ST_ADDR: if (bitcnt == 4'd8) begin
            bitcnt <= '0;
            if (sr[7:1] == TGT_ADDR) begin
              sda_oe <= 1'b1;
              rw     <= sr[0];
              active <= 1'b1;
              state  <= ST_ADDR_ACK;
            end else begin
              active <= 1'b0;
              state  <= ST_WAIT;
            end
          end
          ST_ADDR_ACK: if (rw) begin
            tx     <= rd_data;
            sda_oe <= ~rd_data[7];
            state  <= ST_RDATA;
          end else begin
            sda_oe <= 1'b0;
            state  <= ST_PTR;
          end
          ST_PTR: if (bitcnt == 4'd8) begin
            bitcnt <= '0;
            ptr    <= sr[AW-1:0];
            sda_oe <= 1'b1;
            state  <= ST_PTR_ACK;
          end
          ST_PTR_ACK: begin
            sda_oe <= 1'b0;
            state  <= ST_WDATA;
          end
          ST_WDATA: if (bitcnt == 4'd8) begin
            bitcnt  <= '0;
            wr_en   <= 1'b1;
            wr_data <= sr;
            sda_oe  <= 1'b1;
            state   <= ST_WDATA_ACK;
          end
          ST_WDATA_ACK: begin
            sda_oe <= 1'b0;
            ptr    <= ptr + AW'(1);
            state  <= ST_WDATA;
          end
          ST_RDATA: if (bitcnt == 4'd8) begin
            bitcnt <= '0;
            sda_oe <= 1'b0;
            state  <= ST_RACK;
          end else begin
            sda_oe <= ~tx[tx_idx];
          end
          ST_RACK: if (hack) begin
            tx     <= rd_data;
            sda_oe <= ~rd_data[7];
            state  <= ST_RDATA;
          end else begin
            sda_oe <= 1'b0;
            state  <= ST_WAIT;
          end
          default: ;
        endcase
      end
    end
  end

  // R4: the data line only moves after SCL has been seen low
  a_r4_sda_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !$past(scl_now));

  // R5: never drive SDA while the host owns the acknowledge bit
  a_r5_release_on_host_ack: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RACK) |-> !sda_oe);

  // R3: outside a pointer load the pointer only ever steps by one
  a_r3_ptr_single_step: assert property (@(posedge clk) disable iff (rst)
    ($past(state) != ST_PTR && !$stable(ptr)) |-> (ptr == AW'($past(ptr) + AW'(1))));
endmodule

// File: rtl/snap_regfile.sv
module snap_regfile #(
  parameter int AW       = 6,
  parameter int CLK_REGS = 8,
  parameter int CW       = $clog2(CLK_REGS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [CLK_REGS*8-1:0] live_bus,
  input  logic                  live_upd,
  input  logic                  freeze,
  input  logic                  wr_en,
  input  logic [AW-1:0]         wr_addr,
  input  logic [7:0]            wr_data,
  input  logic [AW-1:0]         rd_addr,
  output logic [7:0]            rd_data,
  output logic                  clk_wr_o,
  output logic [CW-1:0]         clk_wr_addr_o,
  output logic [7:0]            clk_wr_data_o
);
  localparam int DEPTH = 1 << AW;

  logic [CLK_REGS-1:0][7:0] snap;
  logic [CLK_REGS*8-1:0]    hold_buf;
  logic                     pend;
  logic [7:0]               mem [DEPTH];
  logic [7:0]               ram_q, snap_q;
  logic                     sel_q;

  // bus-visible clock copy with freeze and pending refresh
  always_ff @(posedge clk) begin
    if (rst) begin
      snap     <= '0;
      hold_buf <= '0;
      pend     <= 1'b0;
    end else begin
      if (live_upd) hold_buf <= live_bus;
      if (freeze) begin
        if (live_upd) pend <= 1'b1;
      end else if (live_upd) begin
        snap <= live_bus;
        pend <= 1'b0;
      end else if (pend) begin
        snap <= hold_buf;
        pend <= 1'b0;
      end
    end
  end

  // general storage, written to map onto block RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    ram_q <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q         <= 1'b0;
      snap_q        <= '0;
      clk_wr_o      <= 1'b0;
      clk_wr_addr_o <= '0;
      clk_wr_data_o <= '0;
    end else begin
      sel_q    <= (rd_addr < AW'(CLK_REGS));
      snap_q   <= snap[rd_addr[CW-1:0]];
      clk_wr_o <= wr_en && (wr_addr < AW'(CLK_REGS));
      if (wr_en) begin
        clk_wr_addr_o <= wr_addr[CW-1:0];
        clk_wr_data_o <= wr_data;
      end
    end
  end

  assign rd_data = sel_q ? snap_q : ram_q;

  // R9: a frozen copy does not move
  a_r9_frozen_copy_stable: assert property (@(posedge clk) disable iff (rst)
    $past(freeze) |-> $stable(snap));

  // R7: the counter load strobe lasts one cycle
  a_r7_load_pulse_single: assert property (@(posedge clk) disable iff (rst)
    clk_wr_o |=> !clk_wr_o);
endmodule

// File: rtl/i2c_snap_target.sv
module i2c_snap_target #(
  parameter int         AW       = 6,
  parameter int         CLK_REGS = 8,
  parameter logic [6:0] TGT_ADDR = 7'h68
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         scl_i,
  input  logic                         sda_i,
  output logic                         sda_oe_o,
  input  logic [CLK_REGS*8-1:0]        live_time_i,
  input  logic                         live_upd_i,
  output logic                         clk_wr_o,
  output logic [$clog2(CLK_REGS)-1:0]  clk_wr_addr_o,
  output logic [7:0]                   clk_wr_data_o
);
  localparam int CW = $clog2(CLK_REGS);

  logic          scl_rise, scl_fall, start_det, stop_det;
  logic [7:0]    rd_data, wr_data;
  logic [AW-1:0] ptr;
  logic          active, wr_en, freeze;

  i2c_line_sense i_sense (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_tgt_engine #(.AW(AW), .TGT_ADDR(TGT_ADDR)) i_engine (
    .clk       (clk),
    .rst       (rst),
    .scl_now   (scl_i),
    .sda_now   (sda_i),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .rd_data   (rd_data),
    .sda_oe    (sda_oe_o),
    .ptr       (ptr),
    .active    (active),
    .wr_en     (wr_en),
    .wr_data   (wr_data)
  );

  assign freeze = active && (ptr < AW'(CLK_REGS));

  snap_regfile #(.AW(AW), .CLK_REGS(CLK_REGS), .CW(CW)) i_regs (
    .clk           (clk),
    .rst           (rst),
    .live_bus      (live_time_i),
    .live_upd      (live_upd_i),
    .freeze        (freeze),
    .wr_en         (wr_en),
    .wr_addr       (ptr),
    .wr_data       (wr_data),
    .rd_addr       (ptr),
    .rd_data       (rd_data),
    .clk_wr_o      (clk_wr_o),
    .clk_wr_addr_o (clk_wr_addr_o),
    .clk_wr_data_o (clk_wr_data_o)
  );
endmodule

// File: tb/test_i2c_snap_target.sv
module test_i2c_snap_target;
  localparam int Q = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        scl = 1'b1;
  logic        sda_h = 1'b1;
  logic        sda_oe;
  logic        sda_bus;
  logic [63:0] live = '0;
  logic        live_upd = 1'b0;
  logic        clk_wr;
  logic [2:0]  clk_wr_addr;
  logic [7:0]  clk_wr_data;
  int          checks = 0;
  int          fails = 0;
  int          wr_seen = 0;
  logic [2:0]  cap_addr = '0;
  logic [7:0]  cap_data = '0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;
  assign sda_bus = sda_h & ~sda_oe;

  i2c_snap_target i_i2c_snap_target (
    .clk           (clk),
    .rst           (rst),
    .scl_i         (scl),
    .sda_i         (sda_bus),
    .sda_oe_o      (sda_oe),
    .live_time_i   (live),
    .live_upd_i    (live_upd),
    .clk_wr_o      (clk_wr),
    .clk_wr_addr_o (clk_wr_addr),
    .clk_wr_data_o (clk_wr_data)
  );

  always @(posedge clk) if (clk_wr) begin
    wr_seen  <= wr_seen + 1;
    cap_addr <= clk_wr_addr;
    cap_data <= clk_wr_data;
  end

  // address, data
  localparam logic [15:0] VEC [8] = '{16'h085A, 16'h09C3, 16'h1F00, 16'h20FF,
                                      16'h2A81, 16'h3E7E, 16'h1033, 16'h11CC};

  task automatic wq(input int n); repeat (n) @(negedge clk); endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] pat(input int base);
    logic [63:0] v;
    for (int k = 0; k < 8; k++) v[8*k +: 8] = 8'(base + k);
    return v;
  endfunction

  task automatic i_start(); sda_h = 1; wq(Q); scl = 1; wq(Q); sda_h = 0; wq(Q); scl = 0; wq(Q); endtask
  task automatic i_stop();  sda_h = 0; wq(Q); scl = 1; wq(Q); sda_h = 1; wq(Q); endtask

  task automatic send(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_h = b[i]; wq(Q); scl = 1; wq(Q); scl = 0; wq(Q);
    end
    sda_h = 1; wq(Q); scl = 1; wq(Q); ack = ~sda_bus; scl = 0; wq(Q);
  endtask

  task automatic recv(output logic [7:0] b, input logic hack);
    for (int i = 7; i >= 0; i--) begin
      wq(Q); scl = 1; wq(Q); b[i] = sda_bus; scl = 0; wq(Q);
    end
    sda_h = ~hack; wq(Q); scl = 1; wq(2*Q); scl = 0; wq(Q); sda_h = 1;
  endtask

  task automatic set_ptr(input logic [7:0] p);
    logic a;
    i_start(); send(8'hD0, a); send(p, a);
  endtask

  task automatic rd_head();
    logic a;
    i_start(); send(8'hD1, a);
  endtask

  initial begin
    logic [7:0] b;
    logic a;
    logic [63:0] lastp;
    repeat (4) @(negedge clk);
    rst = 0;
    wq(4);
    check("R11 sda released", {7'd0, sda_oe}, 8'h00);
    rd_head(); recv(b, 0); i_stop();
    check("R11 ptr0 copy zero", b, 8'h00);

    // R1 foreign and own address
    i_start(); send(8'hA0, a); i_stop();
    check("R1 foreign nack", {7'd0, a}, 8'h00);
    i_start(); send(8'hD0, a); i_stop();
    check("R1 own ack", {7'd0, a}, 8'h01);

    // vector table: single write then random read (R2 R3 R4)
    for (int v = 0; v < 8; v++) begin
      set_ptr({2'b00, VEC[v][13:8]}); send(VEC[v][7:0], a); i_stop();
      set_ptr({2'b00, VEC[v][13:8]}); rd_head(); recv(b, 0); i_stop();
      check("R2 R3 vector readback", b, VEC[v][7:0]);
    end

    // R4 burst
    set_ptr(8'h30); send(8'h11, a); send(8'h22, a); send(8'h33, a); i_stop();
    set_ptr(8'h30); rd_head();
    recv(b, 1); check("R4 burst 30", b, 8'h11);
    recv(b, 1); check("R4 burst 31", b, 8'h22);
    recv(b, 0); check("R4 burst 32", b, 8'h33);
    i_stop();
    // R5 R6 nack left pointer at 32
    rd_head(); recv(b, 0); i_stop();
    check("R5 R6 no advance on nack", b, 8'h33);

    // R3 wrap and R7 strobe
    set_ptr(8'h3F); send(8'hAB, a); send(8'hCD, a); i_stop();
    wq(4);
    check("R7 one load pulse", 8'(wr_seen), 8'h01);
    check("R7 load addr", {5'd0, cap_addr}, 8'h00);
    check("R3 wrap to 00 data", cap_data, 8'hCD);
    set_ptr(8'h3F); rd_head(); recv(b, 1); check("R3 byte at 3F", b, 8'hAB);
    recv(b, 0); check("R7 copy unchanged by write", b, 8'h00);
    i_stop();

    // R8 live load when idle
    live = pat(8'h10); live_upd = 1; wq(1); live_upd = 0; wq(4);
    set_ptr(8'h00); rd_head();
    for (int k = 0; k < 8; k++) begin
      recv(b, k != 7); check("R8 live byte", b, 8'(8'h10 + k));
    end
    i_stop();

    // R9 freeze inside burst, R10 release past 07
    set_ptr(8'h06); rd_head();
    recv(b, 1); check("R8 byte 06", b, 8'h16);
    live = pat(8'h40); live_upd = 1; wq(1); live_upd = 0;
    recv(b, 1); check("R9 frozen byte 07", b, 8'h17);
    recv(b, 0); check("R10 storage after 07", b, 8'h5A);
    i_stop();
    set_ptr(8'h06); rd_head();
    recv(b, 1); check("R10 refreshed 06", b, 8'h46);
    recv(b, 0); check("R10 refreshed 07", b, 8'h47);
    i_stop();

    // R9 across repeated start, R10 release on STOP
    set_ptr(8'h02); rd_head(); recv(b, 0); check("R9 byte 02", b, 8'h42);
    live = pat(8'h60); live_upd = 1; wq(1); live_upd = 0;
    rd_head(); recv(b, 0); check("R9 held over repeated start", b, 8'h42);
    i_stop();
    rd_head(); recv(b, 0); i_stop();
    check("R10 refreshed on stop", b, 8'h62);

    // R10 update strobe in the cycle the freeze ends
    set_ptr(8'h03); rd_head(); recv(b, 0); check("R9 byte 03", b, 8'h63);
    lastp = '0;
    fork
      i_stop();
      begin
        for (int c = 0; c < 40; c++) begin
          live = pat(c * 8 + 128); live_upd = 1; lastp = live; wq(1);
        end
        live_upd = 0;
      end
    join
    wq(4);
    rd_head(); recv(b, 0); i_stop();
    check("R10 newest value wins", b, lastp[31:24]);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule